// File: doc/BRIEF.md
# Ultra DMA Data-In Host Receiver

This block is the host end of an Ultra DMA read burst, in which the drive supplies the data. It watches the drive's DMA request and its data strobe, and it drives the acknowledge, STOP and host-ready lines. A 16-bit word is taken on every change of the drive strobe, on the rising edge and on the falling edge. The strobe and the data pass through a synchroniser before edges are detected. Each captured word goes into a local buffer, and a consumer drains that buffer through a show-ahead pop port.

The selected transfer mode sets the wait between pausing and asserting STOP. Host ready is withdrawn whenever the buffer is close to full. The margin covers the late words the drive may still send after a pause plus the synchroniser delay. A burst ends in one of two ways: on a host request through a pause-then-STOP sequence, or on the drive's own withdrawal of its request. In both cases the engine holds the acknowledge low for a minimum interlock time. It also reports how many words the latest burst delivered.

Top module: `udma_rx_host`

## Requirements
- R1: After reset and whenever no burst is open, dmack_n_o=1, stop_o=1, hdmardy_n_o=1, and the buffer stays as it was (empty after reset).
- R2: With burst_en_i=1 and dmarq_i=1, dmack_n_o goes to 0. No sooner than ceil(20 ns / clock) cycles later, stop_o=0 and hdmardy_n_o=0 are driven together. hdmardy_n_o=0 never appears unless dmack_n_o=0 and stop_o=0.
- R3: During an open burst, every transition of dstrobe_i stores dd_i as one word, both 0→1 and 1→0. The words are read out in arrival order on rd_data_o, and rd_pop_i=1 advances to the next word.
- R4: Strobe transitions while dmack_n_o=1 store nothing and leave word_cnt_o unchanged.
- R5: hdmardy_n_o=1 whenever fewer than BUF_SLACK (4) buffer entries are free. It returns to 0 once room is restored in a running burst.
- R6: Words that arrive after hdmardy_n_o has risen are still stored. The buffer never overflows.
- R7: On host_stop_i=1 the engine raises hdmardy_n_o. stop_o is asserted no sooner than 70 ns later in modes 0 and 1, and no sooner than 60 ns later in modes 2 to 4 (mode_i values 0..4).
- R8: After a host stop, dmack_n_o stays 0 until dmarq_i has fallen. It then rises no sooner than 20 ns after the synchronised fall.
- R9: If dmarq_i falls during a running burst, the engine asserts stop_o with hdmardy_n_o=1 within a few cycles. It raises dmack_n_o no sooner than 20 ns after that.
- R10: word_cnt_o clears when a burst opens and counts the words stored in that burst. It holds the value after the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock (96 MHz nominal) |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 3 | Ultra DMA mode 0..4 |
| burst_en_i | input | 1 | Allow the engine to accept a drive request |
| host_stop_i | input | 1 | Host request to end the burst |
| dmarq_i | input | 1 | Drive DMA request, active high |
| dstrobe_i | input | 1 | Drive data strobe, asynchronous |
| dd_i | input | DATA_W | Drive data bus |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| stop_o | output | 1 | STOP, active high |
| hdmardy_n_o | output | 1 | Host ready, active low |
| rd_pop_i | input | 1 | Consume the word at the buffer head |
| rd_data_o | output | DATA_W | Word at the buffer head |
| rd_empty_o | output | 1 | Buffer holds no word |
| word_cnt_o | output | CNT_W | Words stored in the latest burst |

## Verification
The bench builds the engine with CLK_PS=5000, a 16-entry buffer and a slack of 4. With these values the 20 ns waits are 4 cycles, and the pause-to-STOP wait is 14 cycles in slow modes and 12 in fast modes, so a wrong mode split shows up as a distinct cycle count. The small buffer lets a dozen words reach the ready threshold. The bench then pushes two late words past that point and drains the buffer to see ready return within the same burst. Bursts end once by host request and once by the drive, each with its interval measured.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // no burst, acknowledge released
    ST_ACK,    // acknowledge given, envelope wait
    ST_RUN,    // data flowing
    ST_PAUSE,  // host ready withdrawn, ready-to-final-strobe wait
    ST_STOPW,  // STOP asserted, waiting for request to drop
    ST_WIND    // interlock wait before releasing acknowledge
  } burst_st_e;

  localparam int ENV_NS      = 20;
  localparam int INTLK_NS    = 20;
  localparam int RFS_SLOW_NS = 70;
  localparam int RFS_FAST_NS = 60;

  // smallest whole number of clock cycles covering ns
  function automatic int ns_to_cycles(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  // modes 0 and 1 use the longer pause-to-stop interval
  function automatic logic mode_is_slow(input logic [2:0] mode);
    return mode < 3'd2;
  endfunction

endpackage

// File: rtl/udma_rx_sync.sv
module udma_rx_sync #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dmarq_i,
  output logic              edge_o,
  output logic [DATA_W-1:0] word_o,
  output logic              dmarq_s_o
);
  logic [2:0]        stb_q;
  logic [DATA_W-1:0] d1_q, d2_q;
  logic [1:0]        rq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      d1_q  <= '0;
      d2_q  <= '0;
      rq_q  <= '0;
    end else begin
      stb_q <= {stb_q[1:0], strobe_i};
      d1_q  <= data_i;
      d2_q  <= d1_q;
      rq_q  <= {rq_q[0], dmarq_i};
    end
  end

  // data travels with the strobe so the word lines up with its edge
  assign edge_o    = stb_q[1] ^ stb_q[2];
  assign word_o    = d2_q;
  assign dmarq_s_o = rq_q[1];
endmodule

// File: rtl/udma_rx_fifo.sv
module udma_rx_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int SLACK  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  output logic              tight_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [AW:0]       level_q;
  logic              full, do_push, do_pop;

  assign full    = level_q == (AW+1)'(DEPTH);
  assign empty_o = level_q == '0;
  assign tight_o = ((AW+1)'(DEPTH) - level_q) < (AW+1)'(SLACK);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign pop_data_o = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      level_q <= level_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full); // R6
endmodule

// File: rtl/udma_rx_ctrl.sv
module udma_rx_ctrl
  import udma_rx_pkg::*;
#(
  parameter int CLK_PS = 10417
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       enable_i,
  input  logic       stop_req_i,
  input  logic       dmarq_s_i,
  input  logic       tight_i,
  output logic       dmack_n_o,
  output logic       stop_o,
  output logic       hdmardy_n_o,
  output logic       accept_o,
  output logic       start_o
);
  localparam int ENV_CYC   = ns_to_cycles(ENV_NS, CLK_PS);
  localparam int INTLK_CYC = ns_to_cycles(INTLK_NS, CLK_PS);
  localparam int RFS_S_CYC = ns_to_cycles(RFS_SLOW_NS, CLK_PS);
  localparam int RFS_F_CYC = ns_to_cycles(RFS_FAST_NS, CLK_PS);
  localparam int CW        = $clog2(RFS_S_CYC + ENV_CYC + INTLK_CYC + 2);

  burst_st_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, rfs_lim;
  logic           timed;

  assign rfs_lim = mode_is_slow(mode_i) ? CW'(RFS_S_CYC - 1) : CW'(RFS_F_CYC - 1);
  assign timed   = (st_q == ST_ACK) || (st_q == ST_PAUSE) || (st_q == ST_WIND);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (enable_i && dmarq_s_i) st_d = ST_ACK;
      ST_ACK:   if (cnt_q == CW'(ENV_CYC - 1)) st_d = ST_RUN;
      ST_RUN:   if (!dmarq_s_i) st_d = ST_WIND;
                else if (stop_req_i) st_d = ST_PAUSE;
      ST_PAUSE: if (!dmarq_s_i) st_d = ST_WIND;
                else if (cnt_q == rfs_lim) st_d = ST_STOPW;
      ST_STOPW: if (!dmarq_s_i) st_d = ST_WIND;
      ST_WIND:  if (cnt_q == CW'(INTLK_CYC - 1)) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : (timed ? cnt_q + 1'b1 : cnt_q);
    end
  end

  assign dmack_n_o   = st_q == ST_IDLE;
  assign stop_o      = !((st_q == ST_RUN) || (st_q == ST_PAUSE));
  assign hdmardy_n_o = !((st_q == ST_RUN) && !tight_i);
  assign accept_o    = (st_q == ST_RUN) || (st_q == ST_PAUSE) ||
                       (st_q == ST_STOPW) || (st_q == ST_WIND);
  assign start_o     = (st_q == ST_IDLE) && (st_d == ST_ACK);

  AST_READY_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !hdmardy_n_o |-> (!dmack_n_o && !stop_o)); // R2
  AST_STOP_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_o) && dmarq_s_i) |-> $past(hdmardy_n_o)); // R7
  AST_RELEASE_AFTER_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmack_n_o) |-> ($past(stop_o) && !$past(dmarq_s_i))); // R8 R9
endmodule

// File: rtl/udma_rx_host.sv
module udma_rx_host #(
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 16,
  parameter int BUF_SLACK = 4,
  parameter int CNT_W     = 16,
  parameter int CLK_PS    = 10417
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              burst_en_i,
  input  logic              host_stop_i,
  input  logic              dmarq_i,
  input  logic              dstrobe_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic              dmack_n_o,
  output logic              stop_o,
  output logic              hdmardy_n_o,
  input  logic              rd_pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o,
  output logic [CNT_W-1:0]  word_cnt_o
);
  logic              stb_edge, dmarq_s, accept, burst_start, buf_tight, word_push;
  logic [DATA_W-1:0] word_in;
  logic [CNT_W-1:0]  cnt_q;

  udma_rx_sync #(.DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(dstrobe_i), .data_i(dd_i),
    .dmarq_i(dmarq_i), .edge_o(stb_edge), .word_o(word_in), .dmarq_s_o(dmarq_s));

  udma_rx_ctrl #(.CLK_PS(CLK_PS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .enable_i(burst_en_i),
    .stop_req_i(host_stop_i), .dmarq_s_i(dmarq_s), .tight_i(buf_tight),
    .dmack_n_o(dmack_n_o), .stop_o(stop_o), .hdmardy_n_o(hdmardy_n_o),
    .accept_o(accept), .start_o(burst_start));

  assign word_push = stb_edge && accept;

  udma_rx_fifo #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .SLACK(BUF_SLACK)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_i(word_push), .push_data_i(word_in),
    .pop_i(rd_pop_i), .pop_data_o(rd_data_o), .empty_o(rd_empty_o),
    .tight_o(buf_tight));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (burst_start) cnt_q <= '0;
    else if (word_push)   cnt_q <= cnt_q + 1'b1;
  end
  assign word_cnt_o = cnt_q;

  AST_CAPTURE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> !dmack_n_o); // R4
  AST_TIGHT_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_tight |-> hdmardy_n_o); // R5
endmodule

// File: tb/udma_rx_host_test.sv
module udma_rx_host_test;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  mode = 0;
  logic        burst_en = 0, host_stop = 0, dmarq = 0, dstrobe = 0, rd_pop = 0;
  logic [15:0] dd = 0;
  logic        dmack_n, stop, hdmardy_n, rd_empty;
  logic [15:0] rd_data, words;

  int nchk = 0, nerr = 0, n = 0;
  bit mon_on = 0, done = 0;
  logic [15:0] expq[$];

  always #2.5 clk = ~clk;

  udma_rx_host #(.DATA_W(16), .BUF_DEPTH(16), .BUF_SLACK(4), .CNT_W(16), .CLK_PS(5000)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .burst_en_i(burst_en),
    .host_stop_i(host_stop), .dmarq_i(dmarq), .dstrobe_i(dstrobe), .dd_i(dd),
    .dmack_n_o(dmack_n), .stop_o(stop), .hdmardy_n_o(hdmardy_n), .rd_pop_i(rd_pop),
    .rd_data_o(rd_data), .rd_empty_o(rd_empty), .word_cnt_o(words));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops the buffer and compares with the expected queue (R3)
  always @(negedge clk) begin
    if (rd_pop) rd_pop = 0;
    else if (mon_on && !rd_empty) begin
      if (expq.size() == 0) chk(0, "R3 unexpected word", int'(rd_data), -1);
      else begin
        chk(rd_data == expq[0], "R3 word order", int'(rd_data), int'(expq[0]));
        void'(expq.pop_front());
      end
      rd_pop = 1;
    end
  end

  // driver: one strobe transition carries one word
  task automatic send_word(input logic [15:0] v, input bit expect_it);
    @(negedge clk) dd = v;
    @(negedge clk) dstrobe = ~dstrobe;
    if (expect_it) expq.push_back(v);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dmack_n == 1, "R1 dmack idle", dmack_n, 1);
    chk(stop == 1, "R1 stop idle", stop, 1);
    chk(hdmardy_n == 1, "R1 ready idle", hdmardy_n, 1);
    chk(rd_empty == 1, "R1 buffer empty", rd_empty, 1);

    // R4: request present but not enabled, strobe toggling is ignored
    dmarq = 1;
    for (int i = 0; i < 3; i++) send_word(16'h0BAD + 16'(i), 0);
    chk(dmack_n == 1, "R4 no ack", dmack_n, 1);
    chk(rd_empty == 1, "R4 nothing stored", rd_empty, 1);
    chk(words == 0, "R4 count unchanged", words, 0);

    // burst 1, mode 0, host termination
    mode = 0; mon_on = 1; burst_en = 1;
    n = 0; while (dmack_n && n < 100) begin @(negedge clk); n++; end
    n = 0; while (hdmardy_n && n < 100) begin @(negedge clk); n++; end
    chk(n >= 4, "R2 envelope wait", n, 4);
    chk(stop == 0, "R2 stop released with ready", stop, 0);
    for (int i = 0; i < 6; i++) send_word(16'h1200 + 16'(i * 7), 1);
    chk(words == 6, "R10 count burst1", words, 6);
    host_stop = 1;
    n = 0; while (!hdmardy_n && n < 100) begin @(negedge clk); n++; end
    n = 0; while (!stop && n < 100) begin @(negedge clk); n++; end
    chk(n >= 14, "R7 mode0 pause-to-stop", n, 14);
    repeat (8) @(negedge clk);
    chk(dmack_n == 0, "R8 ack held while request high", dmack_n, 0);
    dmarq = 0;
    n = 0; while (!dmack_n && n < 100) begin @(negedge clk); n++; end
    chk(n >= 4, "R8 interlock after request drop", n, 4);
    host_stop = 0;
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R3 all words drained", expq.size(), 0);
    chk(words == 6, "R10 count held", words, 6);
    chk(stop == 1 && hdmardy_n == 1, "R1 idle after burst", {stop, hdmardy_n}, 3);

    // burst 2, mode 3, fill to threshold and pause
    mon_on = 0; mode = 3; dmarq = 1;
    n = 0; while (hdmardy_n && n < 100) begin @(negedge clk); n++; end
    chk(words == 0, "R10 cleared at start", words, 0);
    for (int i = 0; i < 12; i++) send_word(16'hA000 + 16'(i), 1);
    chk(hdmardy_n == 0, "R5 ready with 4 free", hdmardy_n, 0);
    send_word(16'hA00C, 1);
    chk(hdmardy_n == 1, "R5 ready withdrawn at 3 free", hdmardy_n, 1);
    send_word(16'hA00D, 1);
    send_word(16'hA00E, 1);
    chk(words == 15, "R6 late words stored", words, 15);
    mon_on = 1;
    repeat (40) @(negedge clk);
    chk(hdmardy_n == 0, "R5 ready restored", hdmardy_n, 0);
    chk(expq.size() == 0, "R6 late words read back", expq.size(), 0);
    host_stop = 1;
    n = 0; while (!hdmardy_n && n < 100) begin @(negedge clk); n++; end
    n = 0; while (!stop && n < 100) begin @(negedge clk); n++; end
    chk(n >= 12 && n < 14, "R7 mode3 pause-to-stop", n, 12);
    dmarq = 0;
    n = 0; while (!dmack_n && n < 100) begin @(negedge clk); n++; end
    host_stop = 0;
    repeat (4) @(negedge clk);

    // burst 3, mode 4, drive termination
    mode = 4; dmarq = 1;
    n = 0; while (hdmardy_n && n < 100) begin @(negedge clk); n++; end
    for (int i = 0; i < 3; i++) send_word(16'h5A5A ^ 16'(i << 4), 1);
    dmarq = 0;
    n = 0; while (!stop && n < 100) begin @(negedge clk); n++; end
    chk(n <= 6, "R9 stop after request drop", n, 6);
    chk(hdmardy_n == 1, "R9 ready withdrawn", hdmardy_n, 1);
    n = 0; while (!dmack_n && n < 100) begin @(negedge clk); n++; end
    chk(n >= 4, "R9 interlock before release", n, 4);
    repeat (10) @(negedge clk);
    chk(words == 3, "R10 count burst3", words, 3);
    chk(rd_empty == 1 && expq.size() == 0, "R3 scoreboard empty", expq.size(), 0);
    finish_run();
  end
endmodule